// File: doc/BRIEF.md
# Multicycle FP Issue Interlock

This block sits at the issue stage of an in-order pipeline that feeds several floating-point execution units of unequal depth. Every cycle it looks at one decoded instruction (its unit class, an optional destination register and up to two source registers) and decides whether the instruction may leave issue now or must be held. It raises `stall` when the instruction has to wait and `issue_ok` when it is accepted. The arithmetic itself, the forwarding muxes and exception handling are not part of it.

The decision rests on predicting when each accepted instruction will write its result. The block keeps three pieces of state. The first is a reservation schedule for the single register write port, one bit for each future cycle. The second is a countdown for each register that gives the cycles left until its pending result lands. The third is a busy countdown for the non-pipelined divider. Operands are read at issue in program order, so a later write never has to wait for an earlier read.

Top module: `fp_issue_interlock`

## Requirements
- R1: `issue_ok` is high exactly when `in_valid` is high and no hazard is present. `stall` is high exactly when `in_valid` is high and a hazard is present. Both are low when `in_valid` is low.
- R2: Unit class codes on `in_unit` are 0 = integer ALU or load (latency 1), 1 = FP add (latency 4), 2 = FP multiply (latency 7) and 3 = FP divide (latency 24). A result from an instruction accepted in cycle t is written in cycle t+latency.
- R3: An instruction whose enabled source register has a pending result stalls. A consumer of a result produced by a unit of latency L and accepted in cycle t is first accepted in cycle t+L.
- R4: An instruction that writes a register stalls if a pending write to that register would land later than its own write.
- R5: An accepted instruction with a destination reserves the write port for its write cycle. A later instruction whose write would fall in an already reserved cycle stalls.
- R6: The divider accepts a new divide at the earliest 24 cycles after the previous accepted divide. Add and multiply instructions can be accepted on consecutive cycles.
- R7: Writing a register that an earlier in-flight instruction reads causes no stall.
- R8: A synchronous active-high `rst` clears all reservations, pending-write countdowns and the divider busy state. In the first cycle after reset, every valid instruction is accepted.
- R9: An instruction with `in_dst_we` low reserves no write slot and creates no pending write.
- R10: A stalled instruction leaves no state behind: it makes no reservation, no pending write and does not occupy the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A decoded instruction is present |
| in_unit | input | 2 | Unit class code (see R2) |
| in_dst_we | input | 1 | Instruction writes a destination register |
| in_dst | input | $clog2(NREG) | Destination register index |
| in_src_a_en | input | 1 | First source operand is used |
| in_src_a | input | $clog2(NREG) | First source register index |
| in_src_b_en | input | 1 | Second source operand is used |
| in_src_b | input | $clog2(NREG) | Second source register index |
| stall | output | 1 | Instruction must be held at issue this cycle |
| issue_ok | output | 1 | Instruction is accepted this cycle |

## Verification
Directed sequences put a single hazard in each cycle, so that each cause can be seen on its own. A dependent read is tried at every distance from an add producer, which places the RAW release exactly on cycle t+4. A short integer write placed behind an add shows a write-port collision with no data dependence. A multiply followed by an add to the same register shows that WAW and port checks hand over correctly as the distance shrinks. Two divides and the multiplies issued between them show that the divider alone blocks and the pipelined units do not. Further sequences cover writes to a register that an in-flight instruction reads, instructions that write nothing, and instructions that were stalled, to show that none of them leaves state behind. Random traffic drawn from a small register window then mixes all classes densely, and an independent cycle model in the bench checks it.

// File: rtl/fpil_pkg.sv
package fpil_pkg;

    typedef enum logic [1:0] {
        UC_INT = 2'd0,
        UC_ADD = 2'd1,
        UC_MUL = 2'd2,
        UC_DIV = 2'd3
    } unit_e;

    typedef struct packed {
        logic raw;
        logic waw;
        logic port;
        logic div;
    } hazard_t;

    function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/fpil_wport_sched.sv
module fpil_wport_sched #(
    parameter int SLOTS = 25,
    parameter int LW    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_en,
    input  logic [LW-1:0] set_idx,
    input  logic [LW-1:0] qry_idx,
    output logic          qry_busy
);
    // slot[k] set: the write port is taken k cycles from now
    logic [SLOTS-1:0] slot;

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        logic hit;
        assign hit = set_en && (set_idx == LW'(k));
        if (k == SLOTS - 1) begin : g_top
            always_ff @(posedge clk) begin
                if (rst) slot[k] <= 1'b0;
                else     slot[k] <= hit;
            end
        end else begin : g_mid
            always_ff @(posedge clk) begin
                if (rst) slot[k] <= 1'b0;
                else     slot[k] <= slot[k+1] | hit;
            end
        end
    end

    assign qry_busy = slot[qry_idx];

endmodule

// File: rtl/fpil_pend_table.sv
module fpil_pend_table #(
    parameter int NREG = 32,
    parameter int AW   = 5,
    parameter int LW   = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_en,
    input  logic [AW-1:0] load_idx,
    input  logic [LW-1:0] load_val,
    input  logic [AW-1:0] rd_a,
    input  logic [AW-1:0] rd_b,
    input  logic [AW-1:0] rd_d,
    output logic [LW-1:0] cnt_a,
    output logic [LW-1:0] cnt_b,
    output logic [LW-1:0] cnt_d
);
    // per register: cycles until its pending result is written, 0 = none
    logic [LW-1:0] cnt [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                cnt[i] <= '0;
            else if (load_en && (load_idx == AW'(i)))
                cnt[i] <= load_val;
            else if (cnt[i] != '0)
                cnt[i] <= cnt[i] - LW'(1);
        end
    end

    assign cnt_a = cnt[rd_a];
    assign cnt_b = cnt[rd_b];
    assign cnt_d = cnt[rd_d];

endmodule

// File: rtl/fpil_div_track.sv
module fpil_div_track #(
    parameter int LAT = 24,
    parameter int LW  = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    logic [LW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (start)
            remain <= LW'(LAT - 1);
        else if (remain != '0)
            remain <= remain - LW'(1);
    end

    assign busy = (remain != '0);

endmodule

// File: rtl/fp_issue_interlock.sv
module fp_issue_interlock
    import fpil_pkg::*;
#(
    parameter int NREG    = 32,
    parameter int LAT_INT = 1,
    parameter int LAT_ADD = 4,
    parameter int LAT_MUL = 7,
    parameter int LAT_DIV = 24
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [1:0]               in_unit,
    input  logic                     in_dst_we,
    input  logic [$clog2(NREG)-1:0]  in_dst,
    input  logic                     in_src_a_en,
    input  logic [$clog2(NREG)-1:0]  in_src_a,
    input  logic                     in_src_b_en,
    input  logic [$clog2(NREG)-1:0]  in_src_b,
    output logic                     stall,
    output logic                     issue_ok
);
    localparam int AW      = $clog2(NREG);
    localparam int MAX_LAT = int'(max_of4(LAT_INT, LAT_ADD, LAT_MUL, LAT_DIV));
    localparam int SLOTS   = MAX_LAT + 1;
    localparam int LW      = $clog2(SLOTS);

    unit_e         unit_q;
    logic [LW-1:0] lat;
    logic [LW-1:0] lat_m1;
    logic [LW-1:0] cnt_a, cnt_b, cnt_d;
    logic          slot_busy;
    logic          div_busy;
    hazard_t       hz;
    logic          any_hz;
    logic          accept;

    assign unit_q = unit_e'(in_unit);

    always_comb begin
        case (unit_q)
            UC_INT:  lat = LW'(LAT_INT);
            UC_ADD:  lat = LW'(LAT_ADD);
            UC_MUL:  lat = LW'(LAT_MUL);
            UC_DIV:  lat = LW'(LAT_DIV);
            default: lat = LW'(LAT_INT);
        endcase
    end

    assign lat_m1 = lat - LW'(1);

    fpil_pend_table #(.NREG(NREG), .AW(AW), .LW(LW)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .load_en  (accept && in_dst_we),
        .load_idx (in_dst),
        .load_val (lat_m1),
        .rd_a     (in_src_a),
        .rd_b     (in_src_b),
        .rd_d     (in_dst),
        .cnt_a    (cnt_a),
        .cnt_b    (cnt_b),
        .cnt_d    (cnt_d)
    );

    fpil_wport_sched #(.SLOTS(SLOTS), .LW(LW)) u_sched (
        .clk      (clk),
        .rst      (rst),
        .set_en   (accept && in_dst_we),
        .set_idx  (lat_m1),
        .qry_idx  (lat),
        .qry_busy (slot_busy)
    );

    fpil_div_track #(.LAT(LAT_DIV), .LW(LW)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (accept && (unit_q == UC_DIV)),
        .busy  (div_busy)
    );

    // a pending count c means that write lands c cycles from now
    always_comb begin
        hz.raw  = (in_src_a_en && (cnt_a != '0)) || (in_src_b_en && (cnt_b != '0));
        hz.waw  = in_dst_we && (cnt_d > lat);
        hz.port = in_dst_we && slot_busy;
        hz.div  = (unit_q == UC_DIV) && div_busy;
    end

    assign any_hz   = |hz;
    assign accept   = in_valid && !any_hz;
    assign issue_ok = accept;
    assign stall    = in_valid && any_hz;

endmodule

// File: rtl/fpil_checker.sv
module fpil_checker
    import fpil_pkg::*;
#(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [1:0]    in_unit,
    input logic          in_dst_we,
    input logic [AW-1:0] in_dst,
    input logic          in_src_a_en,
    input logic [AW-1:0] in_src_a,
    input logic          stall,
    input logic          issue_ok
);
    logic [2:0] cyc;

    always_ff @(posedge clk) begin
        if (rst)             cyc <= '0;
        else if (cyc != 3'd7) cyc <= cyc + 3'd1;
    end

    assert_accept_rule_R1: assert property (@(posedge clk) disable iff (rst)
        issue_ok |-> (in_valid && !stall));

    assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> (!stall && !issue_ok));

    assert_raw_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (issue_ok && in_dst_we && (in_unit != UC_INT))
        |=> !(issue_ok && in_src_a_en && (in_src_a == $past(in_dst))));

    assert_waw_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (issue_ok && in_dst_we && (in_unit == UC_MUL))
        |=> !(issue_ok && in_dst_we && (in_unit == UC_ADD) && (in_dst == $past(in_dst))));

    assert_port_clash_R5: assert property (@(posedge clk) disable iff (rst)
        ((cyc >= 3'd3) && issue_ok && in_dst_we && (in_unit == UC_INT))
        |-> !$past(issue_ok && in_dst_we && (in_unit == UC_ADD), 3));

    assert_div_busy_R6: assert property (@(posedge clk) disable iff (rst)
        (issue_ok && (in_unit == UC_DIV)) |=> !(issue_ok && (in_unit == UC_DIV)));

    assert_clean_reset_R8: assert property (@(posedge clk) disable iff (rst)
        (cyc == 3'd0) |-> (issue_ok == in_valid));

endmodule

bind fp_issue_interlock fpil_checker #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_unit     (in_unit),
    .in_dst_we   (in_dst_we),
    .in_dst      (in_dst),
    .in_src_a_en (in_src_a_en),
    .in_src_a    (in_src_a),
    .stall       (stall),
    .issue_ok    (issue_ok)
);

// File: tb/fp_issue_interlock_tb.sv
module fp_issue_interlock_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NREG  = 32;
    localparam int AW    = $clog2(NREG);
    localparam int SLOTS = 25;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [1:0]    in_unit = '0;
    logic          in_dst_we = 1'b0;
    logic [AW-1:0] in_dst = '0;
    logic          in_src_a_en = 1'b0;
    logic [AW-1:0] in_src_a = '0;
    logic          in_src_b_en = 1'b0;
    logic [AW-1:0] in_src_b = '0;
    logic          stall;
    logic          issue_ok;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int m_cnt [NREG];
    bit m_res [SLOTS];
    int m_div;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_issue_interlock #(.NREG(NREG)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_unit(in_unit),
        .in_dst_we(in_dst_we), .in_dst(in_dst),
        .in_src_a_en(in_src_a_en), .in_src_a(in_src_a),
        .in_src_b_en(in_src_b_en), .in_src_b(in_src_b),
        .stall(stall), .issue_ok(issue_ok)
    );

    function automatic int lat_of(input int u);
        case (u)
            0: return 1;
            1: return 4;
            2: return 7;
            default: return 24;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < NREG; i++) m_cnt[i] = 0;
        for (int k = 0; k < SLOTS; k++) m_res[k] = 1'b0;
        m_div = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    // exp: -1 model only, 0 expect stall, 1 expect accept
    task automatic step(input bit v, input int u, input bit we, input int d,
                        input bit ae, input int a, input bit be, input int b,
                        input int exp, input string tag);
        int  l;
        bit  hz;
        bit  macc;
        @(negedge clk);
        in_valid = v; in_unit = 2'(u); in_dst_we = we; in_dst = AW'(d);
        in_src_a_en = ae; in_src_a = AW'(a); in_src_b_en = be; in_src_b = AW'(b);
        #1;
        l  = lat_of(u);
        hz = (ae && m_cnt[a] != 0) || (be && m_cnt[b] != 0) ||
             (we && m_cnt[d] > l) || (we && m_res[l]) || (u == 3 && m_div != 0);
        macc = v && !hz;
        check({tag, " issue_ok"}, int'(issue_ok), int'(macc));
        check({tag, " stall"}, int'(stall), int'(v && hz));
        if (exp >= 0) check({tag, " directed"}, int'(issue_ok), exp);
        @(posedge clk);
        for (int i = 0; i < NREG; i++) if (m_cnt[i] > 0) m_cnt[i]--;
        for (int k = 0; k < SLOTS - 1; k++) m_res[k] = m_res[k+1];
        m_res[SLOTS-1] = 1'b0;
        if (m_div > 0) m_div--;
        if (macc) begin
            if (we) begin
                m_cnt[d] = l - 1;
                m_res[l-1] = 1'b1;
            end
            if (u == 3) m_div = 23;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, -1, "idle R1");
    endtask

    initial begin
        void'($urandom(32'd20250611));
        model_clear();
        do_reset();

        // R8 / R1: reset state
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 invalid");
        check("R8 stall after reset", int'(stall), 0);

        // R3 / R2: add producer, dependent read at distances 1..4
        step(1, 1, 1, 3, 1, 1, 1, 2, 1, "R2 add accept");
        step(1, 0, 1, 5, 1, 3, 0, 0, 0, "R3 raw d1");
        step(1, 0, 1, 5, 1, 3, 0, 0, 0, "R3 raw d2");
        step(1, 0, 1, 5, 0, 0, 1, 3, 0, "R3 raw d3 srcb");
        step(1, 0, 1, 5, 1, 3, 0, 0, 1, "R3 raw release at t+4");
        idle(6);

        // R5: port clash int behind add
        step(1, 1, 1, 10, 0, 0, 0, 0, 1, "R5 add");
        idle(2);
        step(1, 0, 1, 11, 0, 0, 0, 0, 0, "R5 port clash");
        step(1, 0, 1, 11, 0, 0, 0, 0, 1, "R5 port free");
        idle(8);

        // R4: mul then add to same reg
        step(1, 2, 1, 12, 0, 0, 0, 0, 1, "R4 mul");
        step(1, 1, 1, 12, 0, 0, 0, 0, 0, "R4 waw c6");
        step(1, 1, 1, 12, 0, 0, 0, 0, 0, "R4 waw c5");
        step(1, 1, 1, 12, 0, 0, 0, 0, 0, "R5 same slot c4");
        step(1, 1, 1, 12, 0, 0, 0, 0, 1, "R4 release c3");
        idle(8);

        // R6: divider busy, pipelined mul
        step(1, 3, 1, 20, 0, 0, 0, 0, 1, "R6 div");
        step(1, 3, 1, 21, 0, 0, 0, 0, 0, "R6 div busy");
        step(1, 2, 1, 22, 0, 0, 0, 0, 1, "R6 mul a");
        step(1, 2, 1, 23, 0, 0, 0, 0, 1, "R6 mul b back to back");
        idle(19);
        step(1, 3, 1, 21, 0, 0, 0, 0, 0, "R6 div busy t+23");
        step(1, 3, 1, 21, 0, 0, 0, 0, 1, "R6 div free t+24");
        idle(30);

        // R7: write a register an in-flight add reads
        step(1, 1, 1, 1, 1, 2, 0, 0, 1, "R7 add reads r2");
        step(1, 0, 1, 2, 0, 0, 0, 0, 1, "R7 write r2 no war");
        idle(6);

        // R9: no destination
        step(1, 1, 0, 25, 1, 6, 0, 0, 1, "R9 add no dst");
        step(1, 0, 1, 27, 1, 25, 0, 0, 1, "R9 no pending");
        idle(1);
        step(1, 0, 1, 26, 0, 0, 0, 0, 1, "R9 no slot");
        idle(6);

        // R10: stalled instruction leaves nothing
        step(1, 1, 1, 4, 0, 0, 0, 0, 1, "R10 add");
        step(1, 2, 1, 5, 1, 4, 0, 0, 0, "R10 mul stalled");
        step(1, 0, 1, 9, 1, 5, 0, 0, 1, "R10 no pending from stalled");
        idle(8);

        // random mix on a small register window (R1..R6)
        for (int n = 0; n < 3000; n++) begin
            step(($urandom_range(0, 9) < 8), int'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
                 1'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
                 1'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
                 -1, "R1 random");
        end

        // R8: reset in the middle of pending work
        step(1, 3, 1, 7, 0, 0, 0, 0, -1, "R8 pre div");
        do_reset();
        step(1, 3, 1, 8, 1, 7, 0, 0, 1, "R8 cleared");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule